// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block holds the host-visible programming state of a four-channel DMA controller together with a small per-channel transfer engine. A host writes and reads the block through a byte-wide port made of an index, write data, read data and read/write strobes. Each channel owns a 16-bit current address and a 16-bit current count. Both are reached a byte at a time, and one flip-flop shared by all channels decides whether an access lands on the low byte or the high byte. Every byte the host writes to a channel register goes both to the working copy and to a base copy, which is kept for autoinitialize reloads.

Each channel has a request input and an acknowledge output. An unmasked channel that raises its request is granted a transfer. In fixed priority, the lowest-numbered channel wins, and only one transfer is granted per cycle. At each transfer the address steps up by one and the count steps down by one. The count is loaded with the length minus one, so the final transfer is the one that wraps the count from zero to all ones. That transfer raises terminal count. A single-mode channel then masks itself, and an autoinitialize channel reloads its base values and stays enabled. A channel set to cascade mode is acknowledged but keeps its registers unchanged.

A parameter selects word-channel behaviour. In that variant every register index is doubled, and the address register is understood to hold a word address. The address counter is 16 bits and wraps within those 16 bits. It never carries into the page bits above it, which come from outside this block.

Top module: `chdma_ctrl`

## Requirements
- R1: After reset every channel is masked, the byte pointer selects the low byte, all address and count registers read zero, and dack, tc and ack_dir are zero.
- R2: In the byte variant, channel c's address register is at index 2c and its count register is at index 2c+1. Each access to one of these registers (read or write) hits the byte the pointer selects and then toggles the pointer. The first access after a clear hits the low byte. host_rdata shows the selected byte combinationally while the index selects the register.
- R3: A write to index 12 returns the byte pointer to the low byte, whatever the data.
- R4: A write to index 10 selects the channel with data bits 1:0. Data bit 2 set masks that channel, and bit 2 clear unmasks it.
- R5: A masked channel ignores its request and never drives its acknowledge.
- R6: The lowest-numbered unmasked requesting channel is granted. Its dack bit is high in the cycle after the request is sampled, and at the same edge its address increases by one and its count decreases by one. At most one dack bit is high at a time.
- R7: The transfer that takes the count from 0 raises that channel's tc for one cycle. In single mode the count then reads 0xFFFF.
- R8: In a non-autoinitialize mode, terminal count sets the channel's mask bit, so further requests get no acknowledge.
- R9: A write to index 11 selects the channel with data bits 1:0. Data bit 4 set selects autoinitialize. In autoinitialize mode, terminal count reloads the address and count from the last host-written values, and the channel stays unmasked.
- R10: The 16-bit address counter wraps from 0xFFFF to 0x0000 without any carry outward.
- R11: Mode data bits 7:6 equal to 11 select cascade. A cascade channel is acknowledged, but its address and count stay unchanged and it never raises tc.
- R12: Mode data bits 3:2 give the channel's transfer direction. ack_dir carries the direction of the acknowledged channel while its dack is high, and is zero otherwise.
- R13: With WORD_MODE=1 every register index is doubled: channel 1's address is at index 4 and the pointer clear is at index 24. Odd indices touch nothing and leave the pointer where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx | input | IDX_W | Register index |
| host_wdata | input | DATA_W | Host write byte |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_rdata | output | DATA_W | Selected register byte |
| dreq | input | NUM_CH | Per-channel transfer request |
| dack | output | NUM_CH | Per-channel acknowledge |
| tc | output | NUM_CH | Per-channel terminal-count pulse |
| ack_dir | output | 2 | Direction code of the acknowledged channel |
| cur_addr | output | NUM_CH*2*DATA_W | Current address of each channel, channel 0 in the low bits |

## Verification
The hardest situations to reach are the ones where the count runs out: the single-mode transfer that masks its channel, and the autoinitialize transfer that reloads. Each needs a channel programmed byte by byte through the shared pointer and then held in request for exactly the programmed length. The stimulus loads short counts (one to three transfers) and holds the request several cycles past the end. This shows both the self-mask and the reload followed by continued service. A behavioural model that keeps its own copy of every register is compared on every clock, so a wrong pointer step or a wrong order of update shows up at once.

// File: rtl/chdma_pkg.sv
package chdma_pkg;

    // Fixed register indices (before word-channel scaling)
    localparam int unsigned IDX_MASK = 10;
    localparam int unsigned IDX_MODE = 11;
    localparam int unsigned IDX_CLR  = 12;

    typedef enum logic [1:0] {
        KIND_DEMAND  = 2'b00,
        KIND_SINGLE  = 2'b01,
        KIND_BLOCK   = 2'b10,
        KIND_CASCADE = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       auto_init;
        logic [1:0] dir;
    } chan_mode_t;

    function automatic chan_mode_t unpack_mode(input logic [7:0] b);
        chan_mode_t m;
        m.kind      = xfer_kind_e'(b[7:6]);
        m.auto_init = b[4];
        m.dir       = b[3:2];
        return m;
    endfunction

endpackage

// File: rtl/chdma_host_dec.sv
module chdma_host_dec
    import chdma_pkg::*;
#(
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned NUM_CH    = 4,
    parameter bit          WORD_MODE = 1'b0,
    localparam int unsigned CH_W     = $clog2(NUM_CH)
)(
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [NUM_CH-1:0] ch_sel,
    output logic              is_cnt,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              mask_wr,
    output logic              mode_wr,
    output logic              clr_wr
);

    localparam logic [IDX_W-1:0] SPAN   = IDX_W'(2*NUM_CH);
    localparam logic [IDX_W-1:0] MASK_I = IDX_W'(IDX_MASK);
    localparam logic [IDX_W-1:0] MODE_I = IDX_W'(IDX_MODE);
    localparam logic [IDX_W-1:0] CLR_I  = IDX_W'(IDX_CLR);

    logic [IDX_W-1:0] eff;
    logic             aligned;
    logic             reg_hit;

    generate
        if (WORD_MODE) begin : g_word
            assign eff     = host_idx >> 1;
            assign aligned = ~host_idx[0];
        end else begin : g_byte
            assign eff     = host_idx;
            assign aligned = 1'b1;
        end
    endgenerate

    assign reg_hit = aligned && (eff < SPAN);
    assign is_cnt  = eff[0];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ch_sel[c] = reg_hit && (eff[CH_W:1] == CH_W'(c));
        end
    end

    assign reg_wr  = host_wr && reg_hit;
    assign reg_rd  = host_rd && reg_hit;
    assign mask_wr = host_wr && aligned && (eff == MASK_I);
    assign mode_wr = host_wr && aligned && (eff == MODE_I);
    assign clr_wr  = host_wr && aligned && (eff == CLR_I);

endmodule

// File: rtl/chdma_arb.sv
module chdma_arb #(
    parameter int unsigned NUM_CH = 4
)(
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] grant
);

    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req[c] && !found) begin
                grant[c] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/chdma_chan.sv
module chdma_chan
    import chdma_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = 2*DATA_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mask_wr,
    input  logic              mask_set,
    input  logic              mode_wr,
    input  chan_mode_t        mode_in,
    output logic              masked_o,
    output logic [CNT_W-1:0]  addr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              tc_o,
    output logic [1:0]        dir_o
);

    typedef struct packed {
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] base_addr;
        logic [CNT_W-1:0] base_cnt;
        logic             mask;
        logic             tc;
        chan_mode_t       mode;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        casc;

    assign casc = (s_q.mode.kind == KIND_CASCADE);

    always_comb begin
        s_d    = s_q;
        s_d.tc = 1'b0;

        // transfer engine step
        if (grant && !casc) begin
            s_d.addr = s_q.addr + CNT_W'(1);
            if (s_q.cnt == '0) begin
                s_d.tc = 1'b1;
                if (s_q.mode.auto_init) begin
                    s_d.addr = s_q.base_addr;
                    s_d.cnt  = s_q.base_cnt;
                end else begin
                    s_d.cnt  = '1;
                    s_d.mask = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        // host writes take precedence over the engine step
        if (wr_addr) begin
            if (hi_sel) begin
                s_d.addr[CNT_W-1:DATA_W]      = wdata;
                s_d.base_addr[CNT_W-1:DATA_W] = wdata;
            end else begin
                s_d.addr[DATA_W-1:0]      = wdata;
                s_d.base_addr[DATA_W-1:0] = wdata;
            end
        end
        if (wr_cnt) begin
            if (hi_sel) begin
                s_d.cnt[CNT_W-1:DATA_W]      = wdata;
                s_d.base_cnt[CNT_W-1:DATA_W] = wdata;
            end else begin
                s_d.cnt[DATA_W-1:0]      = wdata;
                s_d.base_cnt[DATA_W-1:0] = wdata;
            end
        end
        if (mask_wr) begin
            s_d.mask = mask_set;
        end
        if (mode_wr) begin
            s_d.mode = mode_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign masked_o = s_q.mask;
    assign addr_o   = s_q.addr;
    assign cnt_o    = s_q.cnt;
    assign tc_o     = s_q.tc;
    assign dir_o    = s_q.mode.dir;

    // R8
    single_tc_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !casc && !s_q.mode.auto_init && s_q.cnt == '0 && !mask_wr && !wr_cnt)
        |=> (s_q.mask && s_q.tc && s_q.cnt == '1));

    // R9
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !casc && s_q.mode.auto_init && s_q.cnt == '0 && !mask_wr && !wr_cnt && !wr_addr)
        |=> (!s_q.mask && s_q.tc && s_q.addr == $past(s_q.base_addr) && s_q.cnt == $past(s_q.base_cnt)));

    // R11
    cascade_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && casc && !wr_addr && !wr_cnt)
        |=> ($stable(s_q.addr) && $stable(s_q.cnt) && !s_q.tc));

    // R10
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !casc && s_q.addr == '1 && s_q.cnt != '0 && !wr_addr)
        |=> (s_q.addr == '0));

endmodule

// File: rtl/chdma_ctrl.sv
module chdma_ctrl
    import chdma_pkg::*;
#(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned IDX_W     = 5,
    parameter bit          WORD_MODE = 1'b0,
    localparam int unsigned CNT_W    = 2*DATA_W
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        host_idx,
    input  logic [DATA_W-1:0]       host_wdata,
    input  logic                    host_wr,
    input  logic                    host_rd,
    output logic [DATA_W-1:0]       host_rdata,
    input  logic [NUM_CH-1:0]       dreq,
    output logic [NUM_CH-1:0]       dack,
    output logic [NUM_CH-1:0]       tc,
    output logic [1:0]              ack_dir,
    output logic [NUM_CH*CNT_W-1:0] cur_addr
);

    localparam int unsigned CH_W = $clog2(NUM_CH);

    typedef struct packed {
        logic              ptr;
        logic [NUM_CH-1:0] dack;
        logic [1:0]        dir;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [NUM_CH-1:0] ch_sel;
    logic              is_cnt, reg_wr, reg_rd, mask_wr, mode_wr, clr_wr;
    logic [NUM_CH-1:0] masked_v, req_ok, grant;
    logic [CNT_W-1:0]  addr_v [NUM_CH];
    logic [CNT_W-1:0]  cnt_v  [NUM_CH];
    logic [1:0]        dir_v  [NUM_CH];
    logic [CNT_W-1:0]  rd_word;
    chan_mode_t        mode_in;

    chdma_host_dec #(
        .IDX_W     (IDX_W),
        .NUM_CH    (NUM_CH),
        .WORD_MODE (WORD_MODE)
    ) i_dec (
        .host_idx (host_idx),
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .ch_sel   (ch_sel),
        .is_cnt   (is_cnt),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .mask_wr  (mask_wr),
        .mode_wr  (mode_wr),
        .clr_wr   (clr_wr)
    );

    assign req_ok  = dreq & ~masked_v;
    assign mode_in = unpack_mode(host_wdata[7:0]);

    chdma_arb #(.NUM_CH(NUM_CH)) i_arb (
        .req   (req_ok),
        .grant (grant)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic sel_me;
            assign sel_me = (host_wdata[CH_W-1:0] == CH_W'(c));

            chdma_chan #(.DATA_W(DATA_W)) i_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .grant    (grant[c]),
                .wr_addr  (reg_wr && ch_sel[c] && !is_cnt),
                .wr_cnt   (reg_wr && ch_sel[c] && is_cnt),
                .hi_sel   (t_q.ptr),
                .wdata    (host_wdata),
                .mask_wr  (mask_wr && sel_me),
                .mask_set (host_wdata[2]),
                .mode_wr  (mode_wr && sel_me),
                .mode_in  (mode_in),
                .masked_o (masked_v[c]),
                .addr_o   (addr_v[c]),
                .cnt_o    (cnt_v[c]),
                .tc_o     (tc[c]),
                .dir_o    (dir_v[c])
            );

            assign cur_addr[c*CNT_W +: CNT_W] = addr_v[c];
        end
    endgenerate

    // read mux
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_sel[c]) begin
                rd_word = is_cnt ? cnt_v[c] : addr_v[c];
            end
        end
        host_rdata = t_q.ptr ? rd_word[CNT_W-1:DATA_W] : rd_word[DATA_W-1:0];
    end

    // next state
    always_comb begin
        t_d = t_q;
        if (clr_wr) begin
            t_d.ptr = 1'b0;
        end else if (reg_wr || reg_rd) begin
            t_d.ptr = ~t_q.ptr;
        end
        t_d.dack = grant;
        t_d.dir  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (grant[c]) begin
                t_d.dir = dir_v[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign dack    = t_q.dack;
    assign ack_dir = t_q.dir;

    // R6
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R5
    masked_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> ((dack & ~$past(req_ok)) == '0));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !t_q.ptr);

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || reg_rd) && !clr_wr) |=> (t_q.ptr != $past(t_q.ptr)));

endmodule

// File: tb/test_chdma_ctrl.sv
`timescale 1ns/1ps
module test_chdma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_idx = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack, tc;
    logic [1:0]  ack_dir;
    logic [63:0] cur_addr;

    logic [4:0]  w_idx = '0;
    logic [7:0]  w_wdata = '0;
    logic        w_wr = 1'b0;
    logic [7:0]  w_rdata;
    logic [3:0]  w_dack, w_tc;
    logic [1:0]  w_dir;
    logic [63:0] w_cur_addr;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    chdma_ctrl i_chdma_ctrl (
        .clk(clk), .rst_n(rst_n), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .dreq(dreq), .dack(dack), .tc(tc), .ack_dir(ack_dir), .cur_addr(cur_addr)
    );

    chdma_ctrl #(.WORD_MODE(1'b1)) i_chdma_ctrl_w (
        .clk(clk), .rst_n(rst_n), .host_idx(w_idx), .host_wdata(w_wdata),
        .host_wr(w_wr), .host_rd(1'b0), .host_rdata(w_rdata),
        .dreq(4'b0000), .dack(w_dack), .tc(w_tc), .ack_dir(w_dir), .cur_addr(w_cur_addr)
    );

    // ---------------- behavioural reference model ----------------
    int m_addr[4], m_cnt[4], m_ba[4], m_bc[4];
    bit m_mask[4], m_auto[4], m_casc[4];
    int m_dir[4];
    bit m_ptr;
    int m_dack, m_tc, m_adir;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_addr[c] = 0; m_cnt[c] = 0; m_ba[c] = 0; m_bc[c] = 0;
                m_mask[c] = 1; m_auto[c] = 0; m_casc[c] = 0; m_dir[c] = 0;
            end
            m_ptr = 0; m_dack = 0; m_tc = 0; m_adir = 0;
        end else begin
            int g;
            g = -1;
            for (int c = 3; c >= 0; c--) if (dreq[c] && !m_mask[c]) g = c;
            m_dack = 0; m_tc = 0; m_adir = 0;
            if (g >= 0) begin
                m_dack = 1 << g;
                m_adir = m_dir[g];
                if (!m_casc[g]) begin
                    m_addr[g] = (m_addr[g] + 1) & 16'hFFFF;
                    if (m_cnt[g] == 0) begin
                        m_tc = 1 << g;
                        if (m_auto[g]) begin
                            m_addr[g] = m_ba[g]; m_cnt[g] = m_bc[g];
                        end else begin
                            m_cnt[g] = 16'hFFFF; m_mask[g] = 1;
                        end
                    end else m_cnt[g] = m_cnt[g] - 1;
                end
            end
            if (host_wr) begin
                if (host_idx < 8) begin
                    int ch, sh;
                    ch = host_idx / 2;
                    sh = m_ptr ? 8 : 0;
                    if (host_idx % 2 == 0) begin
                        m_addr[ch] = (m_addr[ch] & ~(255 << sh)) | (host_wdata << sh);
                        m_ba[ch]   = (m_ba[ch]   & ~(255 << sh)) | (host_wdata << sh);
                    end else begin
                        m_cnt[ch] = (m_cnt[ch] & ~(255 << sh)) | (host_wdata << sh);
                        m_bc[ch]  = (m_bc[ch]  & ~(255 << sh)) | (host_wdata << sh);
                    end
                    m_ptr = !m_ptr;
                end else if (host_idx == 10) begin
                    m_mask[host_wdata[1:0]] = host_wdata[2];
                end else if (host_idx == 11) begin
                    m_dir[host_wdata[1:0]]  = host_wdata[3:2];
                    m_auto[host_wdata[1:0]] = host_wdata[4];
                    m_casc[host_wdata[1:0]] = (host_wdata[7:6] == 2'b11);
                end else if (host_idx == 12) begin
                    m_ptr = 0;
                end
            end else if (host_rd && host_idx < 8) begin
                m_ptr = !m_ptr;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 dack", dack, m_dack);
            chk("R7 tc", tc, m_tc);
            chk("R12 ack_dir", ack_dir, m_adir);
            for (int c = 0; c < 4; c++) chk("R6 cur_addr", cur_addr[c*16 +: 16], m_addr[c]);
            if (host_rd && host_idx < 8) begin
                int w;
                w = (host_idx % 2) ? m_cnt[host_idx/2] : m_addr[host_idx/2];
                chk("R2 rdata", host_rdata, m_ptr ? (w >> 8) & 255 : w & 255);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int idx, input int d);
        host_idx = idx[4:0]; host_wdata = d[7:0]; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output int d);
        host_idx = idx[4:0]; host_rd = 1'b1;
        @(negedge clk); d = host_rdata;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic wwr(input int idx, input int d);
        w_idx = idx[4:0]; w_wdata = d[7:0]; w_wr = 1'b1;
        tick();
        w_wr = 1'b0;
    endtask

    initial begin
        #250000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int d, lo, hi, keep;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk("R1 dack", dack, 0);
        chk("R1 tc", tc, 0);
        chk("R1 cur_addr", cur_addr[31:0], 0);
        rd(1, d); chk("R1 count reads zero", d, 0);
        wr(12, 0);
        // all masked after reset: requests ignored
        dreq = 4'hF; tick(); tick(); @(negedge clk);
        chk("R1 masked after reset", dack, 0);
        dreq = 4'h0; tick();

        // program channel 1: addr 0x1234, count 2 (three transfers), single, dir 01
        wr(12, 0);
        wr(2, 8'h34); wr(2, 8'h12);
        wr(3, 8'h02); wr(3, 8'h00);
        wr(11, 8'h45);
        wr(12, 0);
        rd(2, lo); rd(2, hi);
        chk("R2 addr low byte", lo, 8'h34);
        chk("R2 addr high byte", hi, 8'h12);
        // pointer left high, then cleared
        rd(2, lo);
        wr(12, 8'hA5);
        rd(2, d); chk("R3 clear returns to low byte", d, 8'h34);
        wr(12, 0);
        wr(10, 8'h01);  // R4 unmask ch1
        dreq = 4'b0010;
        tick(); @(negedge clk);
        chk("R6 first ack on ch1", dack, 4'b0010);
        chk("R12 dir of ch1", ack_dir, 1);
        repeat (5) tick();
        dreq = 4'h0;
        @(negedge clk);
        chk("R6 address after three transfers", cur_addr[31:16], 16'h1237);
        chk("R8 ch1 masked after terminal count", dack, 0);
        wr(12, 0);
        rd(3, lo); rd(3, hi);
        chk("R7 count low after tc", lo, 8'hFF);
        chk("R7 count high after tc", hi, 8'hFF);

        // channel 2 autoinitialize: addr 0x0100, count 1, dir 10
        wr(12, 0);
        wr(4, 8'h00); wr(4, 8'h01);
        wr(5, 8'h01); wr(5, 8'h00);
        wr(11, 8'h5A);
        wr(10, 8'h02);
        dreq = 4'b0100;
        tick(); tick(); @(negedge clk);
        chk("R7 tc on ch2", tc, 4'b0100);
        chk("R9 reload address", cur_addr[47:32], 16'h0100);
        tick(); @(negedge clk);
        chk("R9 still unmasked", dack, 4'b0100);
        chk("R12 dir of ch2", ack_dir, 2);
        dreq = 4'h0; tick();

        // priority: ch0 and ch2 both request
        wr(12, 0);
        wr(0, 8'h00); wr(0, 8'h00);
        wr(1, 8'h10); wr(1, 8'h00);
        wr(11, 8'h44);
        wr(10, 8'h00);
        dreq = 4'b0101;
        tick(); @(negedge clk);
        chk("R6 lowest channel wins", dack, 4'b0001);
        dreq = 4'h0;
        wr(10, 8'h04);  // mask ch0
        dreq = 4'b0101;
        tick(); @(negedge clk);
        chk("R4 masked ch0 yields to ch2", dack, 4'b0100);
        dreq = 4'h0; tick();

        // address wrap on ch3
        wr(12, 0);
        wr(6, 8'hFF); wr(6, 8'hFF);
        wr(7, 8'h03); wr(7, 8'h00);
        wr(11, 8'h47);
        wr(10, 8'h03);
        dreq = 4'b1000;
        tick(); dreq = 4'h0; @(negedge clk);
        chk("R10 address wraps to zero", cur_addr[63:48], 0);
        wr(10, 8'h07);
        dreq = 4'b1000; tick(); tick(); @(negedge clk);
        chk("R5 masked ch3 not acknowledged", dack, 0);
        dreq = 4'h0; tick();

        // cascade on ch0
        wr(11, 8'hC0);
        wr(10, 8'h00);
        @(negedge clk); keep = cur_addr[15:0];
        tick();
        dreq = 4'b0001;
        tick(); tick(); @(negedge clk);
        chk("R11 cascade acknowledged", dack, 4'b0001);
        chk("R11 cascade address held", cur_addr[15:0], keep);
        chk("R11 cascade no tc", tc, 0);
        dreq = 4'h0; tick();

        // word variant
        wwr(24, 0);
        wwr(4, 8'h34);
        wwr(5, 8'h99);
        wwr(4, 8'h12);
        @(negedge clk);
        chk("R13 word-scaled address", w_cur_addr[31:16], 16'h1234);
        chk("R13 word ch0 untouched", w_cur_addr[15:0], 0);

        tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule